// File: doc/BRIEF.md
# Stub Level-2 Cache Controller Register Block

This block occupies the register window of a level-2 cache controller in a system that has no second-level cache arrays. Boot and driver software still probe, configure and maintain the controller, so the block answers every access on a 32-bit APB-style bus. Each answer is consistent and completes in a single access phase.

The block holds a one-bit enable, an auxiliary control word, tag and data latency words, and an address-filter start/end pair. It returns a fixed identification word, and a cache-type word that is formed live from a base value and a few auxiliary control fields. Cache maintenance registers always read as finished. A small set of reserved offsets reads as zero and drops writes. Any offset outside the map also reads as zero and drops writes, and it raises a flag for that access.

Top module: `l2_stub_regs`

## Requirements
- R1: Only address bits [11:0] select a register, so an access with any upper address bits reaches the same register as its low-12-bit offset.
- R2: Offset 0x000 reads 0x410000C8 at all times, and writes to it have no effect.
- R3: Offset 0x004 reads BASE | aux[19:17]<<20 | aux[16]<<18 | aux[19:17]<<8 | aux[16]<<6, with BASE defaulting to 0x1C100100. The value is recomputed on every read, so earlier aux values leave no trace.
- R4: Offset 0x100 is the enable register. A write keeps only data bit 0, and bits [31:1] always read as zero.
- R5: Offsets 0x104 (auxiliary control), 0x108 (tag latency) and 0x10C (data latency) are full 32-bit read/write registers.
- R6: Offsets 0xC00 (filter start) and 0xC04 (filter end) are full 32-bit read/write registers.
- R7: Offsets from 0x730 through 0x7FF read as zero, meaning the maintenance operation is complete. Writes to them change no register, and they do not raise the unmapped flag.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read as zero, and writes to them change no register and do not raise the unmapped flag.
- R9: After reset the enable, tag, data, filter start and filter end registers read zero, and auxiliary control reads 0x02020000.
- R10: Any other offset reads zero and drops writes. For such an access, unmapped_o is high during the access phase only and is low at all other times.
- R11: pready_o is high and pslverr_o is low for every access, so every transfer finishes with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Block select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 32 | Byte address; only [11:0] decoded |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| pready_o | output | 1 | Transfer done, always high |
| pslverr_o | output | 1 | Error response, always low |
| unmapped_o | output | 1 | Access phase to an unmapped offset |

## Verification
On every cycle the assertions check several properties. The identification word is fixed. Enable readback has no upper bits. Maintenance and unmapped offsets read zero, and an unmapped access never enables a register write. Each register write lands exactly as written, and with no write enable the registers do not move. The bench scenarios are needed for the rest. They cover the cache-type composition across different auxiliary values, its return to the base word, address aliasing through the upper address bits, the exact edges of the maintenance range, and reset values as seen at the bus.

// File: rtl/l2_stub_pkg.sv
`timescale 1ns/1ps
package l2_stub_pkg;
  localparam int unsigned OFF_W = 12;

  typedef enum logic [2:0] {
    SEL_ID, SEL_CTYPE, SEL_CTRL, SEL_RW, SEL_MAINT, SEL_RSVD, SEL_NONE
  } sel_e;

  // full-width read/write register slots
  localparam int unsigned N_RW      = 5;
  localparam int unsigned RW_AUX    = 0;
  localparam int unsigned RW_TAG    = 1;
  localparam int unsigned RW_DATA   = 2;
  localparam int unsigned RW_FSTART = 3;
  localparam int unsigned RW_FEND   = 4;

  localparam logic [31:0] ID_WORD = 32'h4100_00C8;

  localparam logic [OFF_W-1:0] OFF_ID     = 12'h000;
  localparam logic [OFF_W-1:0] OFF_CTYPE  = 12'h004;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h100;
  localparam logic [OFF_W-1:0] OFF_AUX    = 12'h104;
  localparam logic [OFF_W-1:0] OFF_TAG    = 12'h108;
  localparam logic [OFF_W-1:0] OFF_DATA   = 12'h10C;
  localparam logic [OFF_W-1:0] OFF_FSTART = 12'hC00;
  localparam logic [OFF_W-1:0] OFF_FEND   = 12'hC04;
  localparam logic [OFF_W-1:0] MAINT_LO   = 12'h730;
  localparam logic [OFF_W-1:0] MAINT_END  = 12'h800; // exclusive
  localparam logic [OFF_W-1:0] OFF_RSVD0  = 12'hF40;
  localparam logic [OFF_W-1:0] OFF_RSVD1  = 12'hF60;
  localparam logic [OFF_W-1:0] OFF_RSVD2  = 12'hF80;
endpackage

// File: rtl/l2_stub_decode.sv
`timescale 1ns/1ps
module l2_stub_decode
  import l2_stub_pkg::*;
#(
  parameter int unsigned NRW = N_RW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    access_i,
  input  logic                    write_i,
  input  logic [OFF_W-1:0]        off_i,
  output sel_e                    sel_o,
  output logic [$clog2(NRW)-1:0]  rw_idx_o,
  output logic                    ctrl_we_o,
  output logic [NRW-1:0]          rw_we_o,
  output logic                    unmapped_o
);
  localparam int unsigned IW = $clog2(NRW);

  always_comb begin
    sel_o    = SEL_NONE;
    rw_idx_o = '0;
    // maintenance window takes priority over the exact-offset map
    if (off_i >= MAINT_LO && off_i < MAINT_END) begin
      sel_o = SEL_MAINT;
    end else begin
      unique case (off_i)
        OFF_ID:     sel_o = SEL_ID;
        OFF_CTYPE:  sel_o = SEL_CTYPE;
        OFF_CTRL:   sel_o = SEL_CTRL;
        OFF_AUX:    begin sel_o = SEL_RW; rw_idx_o = IW'(RW_AUX);    end
        OFF_TAG:    begin sel_o = SEL_RW; rw_idx_o = IW'(RW_TAG);    end
        OFF_DATA:   begin sel_o = SEL_RW; rw_idx_o = IW'(RW_DATA);   end
        OFF_FSTART: begin sel_o = SEL_RW; rw_idx_o = IW'(RW_FSTART); end
        OFF_FEND:   begin sel_o = SEL_RW; rw_idx_o = IW'(RW_FEND);   end
        OFF_RSVD0, OFF_RSVD1, OFF_RSVD2: sel_o = SEL_RSVD;
        default:    sel_o = SEL_NONE;
      endcase
    end
  end

  assign ctrl_we_o  = write_i && (sel_o == SEL_CTRL);
  assign unmapped_o = access_i && (sel_o == SEL_NONE);

  for (genvar g = 0; g < NRW; g++) begin : g_we
    assign rw_we_o[g] = write_i && (sel_o == SEL_RW) && (rw_idx_o == IW'(g));
  end

  a_r10_unmapped_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> (!ctrl_we_o && rw_we_o == '0));

  a_r5_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_we_o, rw_we_o}));
endmodule

// File: rtl/l2_stub_regfile.sv
`timescale 1ns/1ps
module l2_stub_regfile
  import l2_stub_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned NRW     = N_RW,
  parameter logic [DW-1:0] AUX_RST = 32'h0202_0000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctrl_we_i,
  input  logic [NRW-1:0]          rw_we_i,
  input  logic [DW-1:0]           wdata_i,
  output logic                    ctrl_o,
  output logic [NRW-1:0][DW-1:0]  rw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_o <= 1'b0;
    else if (ctrl_we_i) ctrl_o <= wdata_i[0];
  end

  for (genvar g = 0; g < NRW; g++) begin : g_rw
    localparam logic [DW-1:0] RST_VAL = (g == RW_AUX) ? AUX_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         rw_o[g] <= RST_VAL;
      else if (rw_we_i[g]) rw_o[g] <= wdata_i;
    end

    a_r5_rw_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rw_we_i[g] |=> (rw_o[g] == $past(wdata_i)));
  end

  a_r4_ctrl_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_o == $past(wdata_i[0])));

  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_we_i && rw_we_i == '0) |=> ($stable(rw_o) && $stable(ctrl_o)));
endmodule

// File: rtl/l2_stub_ctype.sv
`timescale 1ns/1ps
module l2_stub_ctype #(
  parameter int unsigned   DW   = 32,
  parameter logic [DW-1:0] BASE = 32'h1C10_0100
) (
  input  logic [3:0]    aux_fld_i,  // aux control bits [19:16]
  output logic [DW-1:0] ctype_o
);
  logic [2:0] way_f;
  logic       size_f;
  assign way_f  = aux_fld_i[3:1];
  assign size_f = aux_fld_i[0];

  // same field lands in both the data-side and instruction-side halves
  assign ctype_o = BASE
                 | (DW'(way_f)  << 20) | (DW'(size_f) << 18)
                 | (DW'(way_f)  << 8)  | (DW'(size_f) << 6);
endmodule

// File: rtl/l2_stub_regs.sv
`timescale 1ns/1ps
module l2_stub_regs
  import l2_stub_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   DW         = 32,
  parameter logic [DW-1:0] CTYPE_BASE = 32'h1C10_0100,
  parameter logic [DW-1:0] AUX_RST    = 32'h0202_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          psel_i,
  input  logic          penable_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [DW-1:0] pwdata_i,
  output logic [DW-1:0] prdata_o,
  output logic          pready_o,
  output logic          pslverr_o,
  output logic          unmapped_o
);
  localparam int unsigned IW = $clog2(N_RW);

  logic                   access, wr;
  logic [OFF_W-1:0]       off;
  logic                   addr_hi_unused;
  sel_e                   sel;
  logic [IW-1:0]          rw_idx;
  logic                   ctrl_we;
  logic [N_RW-1:0]        rw_we;
  logic                   ctrl_q;
  logic [N_RW-1:0][DW-1:0] rw_q;
  logic [DW-1:0]          ctype;
  logic [DW-1:0]          rw_rd;

  assign access         = psel_i && penable_i;
  assign wr             = access && pwrite_i;
  assign off            = paddr_i[OFF_W-1:0];
  assign addr_hi_unused = ^paddr_i[AW-1:OFF_W];

  l2_stub_decode #(.NRW(N_RW)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .access_i   (access),
    .write_i    (wr),
    .off_i      (off),
    .sel_o      (sel),
    .rw_idx_o   (rw_idx),
    .ctrl_we_o  (ctrl_we),
    .rw_we_o    (rw_we),
    .unmapped_o (unmapped_o)
  );

  l2_stub_regfile #(.DW(DW), .NRW(N_RW), .AUX_RST(AUX_RST)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .rw_we_i   (rw_we),
    .wdata_i   (pwdata_i),
    .ctrl_o    (ctrl_q),
    .rw_o      (rw_q)
  );

  l2_stub_ctype #(.DW(DW), .BASE(CTYPE_BASE)) u_ctype (
    .aux_fld_i (rw_q[RW_AUX][19:16]),
    .ctype_o   (ctype)
  );

  always_comb begin
    rw_rd = '0;
    for (int i = 0; i < N_RW; i++)
      if (rw_idx == IW'(i)) rw_rd = rw_q[i];
  end

  always_comb begin
    unique case (sel)
      SEL_ID:    prdata_o = DW'(ID_WORD);
      SEL_CTYPE: prdata_o = ctype;
      SEL_CTRL:  prdata_o = DW'(ctrl_q);
      SEL_RW:    prdata_o = rw_rd;
      default:   prdata_o = '0;  // maintenance done, reserved, unmapped
    endcase
  end

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  a_r2_id_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && off == OFF_ID) |-> (prdata_o == DW'(ID_WORD)));

  a_r4_enable_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && off == OFF_CTRL) |-> (prdata_o[DW-1:1] == '0));

  a_r7_maint_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && off >= MAINT_LO && off < MAINT_END) |-> (prdata_o == '0 && !unmapped_o));

  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> (prdata_o == '0 && access));
endmodule

// File: tb/l2_stub_regs_tb_top.sv
`timescale 1ns/1ps
module l2_stub_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        psel, penable, pwrite;
  logic [31:0] paddr, pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr, unmapped;

  always #2.5 clk = ~clk;  // 200 MHz

  l2_stub_regs dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .psel_i     (psel),
    .penable_i  (penable),
    .pwrite_i   (pwrite),
    .paddr_i    (paddr),
    .pwdata_i   (pwdata),
    .prdata_o   (prdata),
    .pready_o   (pready),
    .pslverr_o  (pslverr),
    .unmapped_o (unmapped)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_data_q[$];
  bit          exp_rd_q[$];
  bit          exp_flag_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctype_model(input logic [31:0] aux);
    return 32'h1C10_0100
         | (32'(aux[19:17]) << 20) | (32'(aux[16]) << 18)
         | (32'(aux[19:17]) << 8)  | (32'(aux[16]) << 6);
  endfunction

  // driver: queue the expectation, then run setup and access phases
  task automatic xfer(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                      input logic [31:0] exp, input bit flag, input string tag);
    exp_data_q.push_back(exp);
    exp_rd_q.push_back(!wr);
    exp_flag_q.push_back(flag);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wd;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
    @(negedge clk);
    check(unmapped == 1'b0, "R10", "flag outside access", 32'(unmapped), 32'h0);
  endtask

  task automatic rd(input logic [31:0] addr, input logic [31:0] exp, input string tag);
    xfer(1'b0, addr, 32'h0, exp, 1'b0, tag);
  endtask

  task automatic wr(input logic [31:0] addr, input logic [31:0] d, input string tag);
    xfer(1'b1, addr, d, 32'h0, 1'b0, tag);
  endtask

  // monitor: pop and compare during each access phase
  always @(negedge clk) begin
    if (rst_ni && psel && penable) begin
      if (exp_data_q.size() == 0) begin
        check(1'b0, "R11", "unexpected access", 32'h1, 32'h0);
      end else begin
        logic [31:0] e;
        bit          r, f;
        string       t;
        e = exp_data_q.pop_front();
        r = exp_rd_q.pop_front();
        f = exp_flag_q.pop_front();
        t = tag_q.pop_front();
        if (r) check(prdata == e, t, "read data", prdata, e);
        check(unmapped == f, (f ? "R10" : t), "unmapped flag", 32'(unmapped), 32'(f));
        check(pready && !pslverr, "R11", "ready/okay", {30'h0, pready, pslverr}, 32'h2);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    check(unmapped == 1'b0, "R9", "flag after reset", 32'(unmapped), 32'h0);

    // R9 reset values
    rd(32'h100, 32'h0,         "R9");
    rd(32'h104, 32'h0202_0000, "R9");
    rd(32'h108, 32'h0,         "R9");
    rd(32'h10C, 32'h0,         "R9");
    rd(32'hC00, 32'h0,         "R9");
    rd(32'hC04, 32'h0,         "R9");
    rd(32'h004, ctype_model(32'h0202_0000), "R3");

    // R2 identification is fixed
    rd(32'h000, 32'h4100_00C8, "R2");
    wr(32'h000, 32'hFFFF_FFFF, "R2");
    rd(32'h000, 32'h4100_00C8, "R2");

    // R4 enable keeps bit 0 only
    wr(32'h100, 32'hFFFF_FFFE, "R4");
    rd(32'h100, 32'h0, "R4");
    wr(32'h100, 32'h0000_0003, "R4");
    rd(32'h100, 32'h1, "R4");

    // R5 latency / aux registers
    wr(32'h108, 32'hA5A5_5A5A, "R5");
    wr(32'h10C, 32'h1234_5678, "R5");
    rd(32'h108, 32'hA5A5_5A5A, "R5");
    rd(32'h10C, 32'h1234_5678, "R5");
    wr(32'h104, 32'hFFFF_FFFF, "R5");
    rd(32'h104, 32'hFFFF_FFFF, "R5");

    // R3 cache type follows aux live, no accumulation
    rd(32'h004, ctype_model(32'hFFFF_FFFF), "R3");
    wr(32'h104, 32'h0001_0000, "R3");
    rd(32'h004, ctype_model(32'h0001_0000), "R3");
    wr(32'h104, 32'h000A_0000, "R3");
    rd(32'h004, ctype_model(32'h000A_0000), "R3");
    wr(32'h104, 32'h0, "R3");
    rd(32'h004, 32'h1C10_0100, "R3");

    // R6 address filter
    wr(32'hC00, 32'h8000_0000, "R6");
    wr(32'hC04, 32'hBFFF_FFFF, "R6");
    rd(32'hC00, 32'h8000_0000, "R6");
    rd(32'hC04, 32'hBFFF_FFFF, "R6");

    // R1 upper address bits ignored
    wr(32'h5000_0C00, 32'h0F0F_0F0F, "R1");
    rd(32'h0000_0C00, 32'h0F0F_0F0F, "R1");
    rd(32'hABCD_E10C, 32'h1234_5678, "R1");
    rd(32'hFFFF_F000, 32'h4100_00C8, "R1");

    // R7 maintenance window, edges included
    wr(32'h730, 32'hDEAD_BEEF, "R7");
    wr(32'h7FC, 32'hDEAD_BEEF, "R7");
    rd(32'h730, 32'h0, "R7");
    rd(32'h7FF, 32'h0, "R7");
    rd(32'h10C, 32'h1234_5678, "R7");
    rd(32'hC04, 32'hBFFF_FFFF, "R7");
    rd(32'h100, 32'h1, "R7");
    xfer(1'b0, 32'h72C, 32'h0, 32'h0, 1'b1, "R10");
    xfer(1'b0, 32'h800, 32'h0, 32'h0, 1'b1, "R10");

    // R8 reserved offsets
    wr(32'hF40, 32'hFFFF_FFFF, "R8");
    wr(32'hF60, 32'hFFFF_FFFF, "R8");
    wr(32'hF80, 32'hFFFF_FFFF, "R8");
    rd(32'hF40, 32'h0, "R8");
    rd(32'hF60, 32'h0, "R8");
    rd(32'hF80, 32'h0, "R8");
    rd(32'h108, 32'hA5A5_5A5A, "R8");

    // R10 unmapped offsets
    xfer(1'b1, 32'h200, 32'hFFFF_FFFF, 32'h0, 1'b1, "R10");
    xfer(1'b0, 32'h200, 32'h0, 32'h0, 1'b1, "R10");
    xfer(1'b1, 32'h105, 32'hFFFF_FFFF, 32'h0, 1'b1, "R10");
    rd(32'h104, 32'h0, "R10");
    rd(32'hC00, 32'h0F0F_0F0F, "R10");
    xfer(1'b0, 32'hFFC, 32'h0, 32'h0, 1'b1, "R10");
    rd(32'h100, 32'h1, "R10");

    repeat (3) @(posedge clk);
    check(exp_data_q.size() == 0, "R11", "pending expectations",
          32'(exp_data_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule